// File: doc/BRIEF.md
# Serial Channel Register Front-End

This block is the bus-facing register set for one channel of a two-channel serial port. A byte-wide host bus reaches each channel through a 32-byte window, and a parameter picks which window this instance answers. Inside the window the host finds a command register, two framing-mode registers that share a single offset, a rate-select register, a status register, and the receive and transmit holding registers. The serializer is a separate core. This block drives that core's enables, one-cycle reset pulses, break level, frame shape and rate codes, and it takes back the core's hand-shakes and receive error flags.

The two mode registers sit behind a pointer. The pointer moves forward on each write to the mode offset and stays on the second register until a command sends it back. One command write can carry a three-bit command code and independent enable/disable bits for each direction. Host accesses are decoded from `bus_wr`/`bus_rd` with `bus_addr`, and take effect on the rising clock edge of the cycle in which they are presented. Read data is combinational from the current register state.

Top module: `uart_chan_regs`

## Requirements
- R1: Only addresses whose bits above the low five equal `CHAN_IDX` reach this channel, at offsets 0x00 (mode), 0x04 (rate select on write, status on read), 0x08 (command, write) and 0x0C (transmit holding on write, receive holding on read). Any other access changes no register, and its read data is 0x00.
- R2: Hardware reset points the mode pointer at MR1. Command code 1 also returns it to MR1. A write at offset 0x00 loads the pointed register and then moves the pointer to MR2, where it stays on further writes. A read at 0x00 returns the pointed register and does not move the pointer.
- R3: MR1 bits [1:0] give the character length (0 means 5 bits, up to 3 meaning 8 bits). Bit 2 selects odd parity. Parity is generated only when bits [4:3] are 2'b00. `core_frame_bits` equals 1 start bit plus the data bits, plus 1 if parity is on, plus the stop bits.
- R4: MR2 bit 3 selects two stop bits, so 0x0F means two and 0x07 means one.
- R5: The rate-select register drives `core_rx_baud` from its bits [7:4] and `core_tx_baud` from its bits [3:0].
- R6: Command bits set the enables: bit 0 turns the receiver on, bit 1 turns it off, bit 2 turns the transmitter on and bit 3 turns it off. When both the on and off bits for one direction are set, off wins. Bits for the two directions act together in one write.
- R7: Command bits [6:4] hold the command code. Code 2 pulses `core_rx_rst` for one cycle and clears the receiver enable. Code 3 pulses `core_tx_rst`, clears the transmitter enable and ends any break. An on bit in the same write re-enables that direction. Code 6 raises `core_brk` and code 7 lowers it. Codes 0, 4 and 5 have no effect.
- R8: The status byte is {break, framing error, parity error, overrun, transmitter empty, transmitter ready, 0, receiver ready}, from bit 7 down to bit 0.
- R9: A `core_rx_push` while the receiver is enabled loads the receive holding register and its break, framing and parity flags, and sets receiver ready. A push while the receiver is disabled is ignored. Reading the receive holding register clears receiver ready and the three per-character flags, unless a push lands in the same cycle, in which case the new character is held and ready stays set.
- R10: A push while receiver ready is set and no read occurs in the same cycle sets overrun. Overrun then stays set until a receiver reset or hardware reset.
- R11: A write to the transmit holding register latches the byte on `core_tx_data`, pulses `core_tx_load` and clears transmitter ready. `core_tx_take` sets ready again, but a write in the same cycle wins. Transmitter empty equals transmitter ready AND `core_tx_idle`.
- R12: The receiver-reset command clears receiver ready and all four error flags. The transmitter-reset command sets transmitter ready.
- R13: After hardware reset, MR1 is 0x13, MR2 is 0x07, rate select is 0xBB, both enables and the break are off, transmitter ready is set and receiver ready is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Host write strobe |
| bus_rd | input | 1 | Host read strobe |
| bus_addr | input | ADDR_W | Host byte address |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Host read data, combinational |
| core_rx_en | output | 1 | Receiver enable |
| core_tx_en | output | 1 | Transmitter enable |
| core_rx_rst | output | 1 | One-cycle receiver reset pulse |
| core_tx_rst | output | 1 | One-cycle transmitter reset pulse |
| core_brk | output | 1 | Send break level |
| core_len_code | output | 2 | Character length code |
| core_par_on | output | 1 | Parity generated and checked |
| core_par_odd | output | 1 | Odd parity |
| core_stop2 | output | 1 | Two stop bits |
| core_frame_bits | output | 4 | Total bits per character frame |
| core_rx_baud | output | 4 | Receive rate code |
| core_tx_baud | output | 4 | Transmit rate code |
| core_tx_data | output | 8 | Transmit holding byte |
| core_tx_load | output | 1 | One-cycle pulse after a transmit write |
| core_tx_take | input | 1 | Core has taken the transmit byte |
| core_tx_idle | input | 1 | Core shifter is idle |
| core_rx_push | input | 1 | Core delivers a received character |
| core_rx_data | input | 8 | Received character |
| core_rx_brk | input | 1 | Character was a break |
| core_rx_fe | input | 1 | Character had a framing error |
| core_rx_pe | input | 1 | Character had a parity error |

## Verification
Two pairs of events can fall in the same clock cycle. A host read of the receive holding register can meet a core push, and a host write of the transmit holding register can meet a core take. The bench provokes each pair by raising the bus strobe and the core strobe between the same two edges. It judges the outcome from the read data returned and from the status byte that follows. After the read-plus-push cycle, the old character must be returned, ready must stay set with the new character held, and no overrun may be added. After the write-plus-take cycle, transmitter ready must read as cleared.

// File: rtl/uchr_pkg.sv
package uchr_pkg;

  localparam logic [7:0] OFS_MODE = 8'h00;
  localparam logic [7:0] OFS_STAT = 8'h04;
  localparam logic [7:0] OFS_CMD  = 8'h08;
  localparam logic [7:0] OFS_DATA = 8'h0C;

  localparam logic [2:0] CMD_PTR_RST = 3'd1;
  localparam logic [2:0] CMD_RX_RST  = 3'd2;
  localparam logic [2:0] CMD_TX_RST  = 3'd3;
  localparam logic [2:0] CMD_BRK_ON  = 3'd6;
  localparam logic [2:0] CMD_BRK_OFF = 3'd7;

  localparam logic [7:0] MR1_RST = 8'h13;
  localparam logic [7:0] MR2_RST = 8'h07;
  localparam logic [7:0] CSR_RST = 8'hBB;

  typedef struct packed {
    logic [1:0] len_code;
    logic       par_on;
    logic       par_odd;
    logic       stop2;
  } frame_cfg_t;

  function automatic frame_cfg_t decode_frame(input logic [7:0] m1, input logic [7:0] m2);
    frame_cfg_t c;
    c.len_code = m1[1:0];
    c.par_on   = (m1[4:3] == 2'b00);
    c.par_odd  = m1[2];
    c.stop2    = m2[3];
    return c;
  endfunction

  function automatic logic [3:0] frame_bits(input frame_cfg_t c);
    return 4'd1 + 4'd5 + {2'b00, c.len_code} + {3'b000, c.par_on}
         + 4'd1 + {3'b000, c.stop2};
  endfunction

  function automatic logic enable_next(input logic cur, input logic on_b,
                                       input logic off_b, input logic rst_b);
    if (off_b)      return 1'b0;
    else if (on_b)  return 1'b1;
    else if (rst_b) return 1'b0;
    else            return cur;
  endfunction

  function automatic logic [7:0] pack_status(input logic brk, input logic fe,
                                             input logic pe, input logic ovr,
                                             input logic temt, input logic txrdy,
                                             input logic rxrdy);
    return {brk, fe, pe, ovr, temt, txrdy, 1'b0, rxrdy};
  endfunction

endpackage

// File: rtl/uchr_addr_dec.sv
module uchr_addr_dec
  import uchr_pkg::*;
#(
  parameter int ADDR_W     = 6,
  parameter int STRIDE_LG2 = 5,
  parameter int CHAN_IDX   = 0
) (
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic              chan_hit,
  output logic              mode_wr,
  output logic              csr_wr,
  output logic              cmd_wr,
  output logic              thr_wr,
  output logic              mode_rd,
  output logic              sr_rd,
  output logic              rhr_rd
);
  localparam int SEL_W = ADDR_W - STRIDE_LG2;
  localparam logic [SEL_W-1:0] MY_SEL = SEL_W'(CHAN_IDX);

  logic [7:0] ofs;

  assign ofs      = 8'(bus_addr[STRIDE_LG2-1:0]);
  assign chan_hit = (bus_addr[ADDR_W-1:STRIDE_LG2] == MY_SEL);

  assign mode_wr = bus_wr && chan_hit && (ofs == OFS_MODE);
  assign csr_wr  = bus_wr && chan_hit && (ofs == OFS_STAT);
  assign cmd_wr  = bus_wr && chan_hit && (ofs == OFS_CMD);
  assign thr_wr  = bus_wr && chan_hit && (ofs == OFS_DATA);
  assign mode_rd = bus_rd && chan_hit && (ofs == OFS_MODE);
  assign sr_rd   = bus_rd && chan_hit && (ofs == OFS_STAT);
  assign rhr_rd  = bus_rd && chan_hit && (ofs == OFS_DATA);

  always_comb begin
    AST_ONE_WR_STROBE: assert ($onehot0({mode_wr, csr_wr, cmd_wr, thr_wr})); // R1
  end
endmodule

// File: rtl/uchr_mode_regs.sv
module uchr_mode_regs
  import uchr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode_wr,
  input  logic       csr_wr,
  input  logic       ptr_rst,
  input  logic [7:0] wdata,
  output logic [7:0] mr1,
  output logic [7:0] mr2,
  output logic [7:0] csr,
  output logic       ptr_at_mr2,
  output frame_cfg_t cfg
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mr1        <= MR1_RST;
      mr2        <= MR2_RST;
      csr        <= CSR_RST;
      ptr_at_mr2 <= 1'b0;
    end else begin
      if (ptr_rst) ptr_at_mr2 <= 1'b0;
      if (mode_wr) begin
        if (ptr_at_mr2) mr2 <= wdata;
        else            mr1 <= wdata;
        ptr_at_mr2 <= 1'b1;
      end
      if (csr_wr) csr <= wdata;
    end
  end

  assign cfg = decode_frame(mr1, mr2);

  AST_PTR_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    mode_wr && !ptr_at_mr2 |=> ptr_at_mr2); // R2
  AST_PTR_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_rst && !mode_wr |=> !ptr_at_mr2); // R2
  AST_MR1_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    mode_wr && !ptr_at_mr2 |=> mr1 == $past(wdata) && $stable(mr2)); // R2
  AST_MR2_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    mode_wr && ptr_at_mr2 |=> mr2 == $past(wdata) && $stable(mr1)); // R4
endmodule

// File: rtl/uchr_cmd.sv
module uchr_cmd
  import uchr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_wr,
  input  logic [7:0] wdata,
  output logic       ptr_rst_ev,
  output logic       rx_rst_ev,
  output logic       tx_rst_ev,
  output logic       rx_en,
  output logic       tx_en,
  output logic       brk_on,
  output logic       rx_rst_pulse,
  output logic       tx_rst_pulse
);
  logic [2:0] code;
  logic       brk_set_ev;
  logic       brk_clr_ev;

  assign code       = wdata[6:4];
  assign ptr_rst_ev = cmd_wr && (code == CMD_PTR_RST);
  assign rx_rst_ev  = cmd_wr && (code == CMD_RX_RST);
  assign tx_rst_ev  = cmd_wr && (code == CMD_TX_RST);
  assign brk_set_ev = cmd_wr && (code == CMD_BRK_ON);
  assign brk_clr_ev = cmd_wr && (code == CMD_BRK_OFF);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_en        <= 1'b0;
      tx_en        <= 1'b0;
      brk_on       <= 1'b0;
      rx_rst_pulse <= 1'b0;
      tx_rst_pulse <= 1'b0;
    end else begin
      rx_rst_pulse <= rx_rst_ev;
      tx_rst_pulse <= tx_rst_ev;
      if (cmd_wr) begin
        rx_en <= enable_next(rx_en, wdata[0], wdata[1], rx_rst_ev);
        tx_en <= enable_next(tx_en, wdata[2], wdata[3], tx_rst_ev);
      end
      if (brk_clr_ev || tx_rst_ev) brk_on <= 1'b0;
      else if (brk_set_ev)         brk_on <= 1'b1;
    end
  end

  AST_RX_OFF_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr && wdata[1] |=> !rx_en); // R6
  AST_TX_ON: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr && wdata[2] && !wdata[3] |=> tx_en); // R6
  AST_BRK_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    brk_set_ev |=> brk_on); // R7
  AST_TXRST_ENDS_BRK: assert property (@(posedge clk) disable iff (!rst_n)
    tx_rst_ev |=> !brk_on && tx_rst_pulse); // R7
  AST_RXRST_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_rst_ev |=> rx_rst_pulse); // R7
endmodule

// File: rtl/uchr_status.sv
module uchr_status
  import uchr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_en,
  input  logic       rx_rst_ev,
  input  logic       tx_rst_ev,
  input  logic       rhr_rd,
  input  logic       thr_wr,
  input  logic [7:0] wdata,
  input  logic       rx_push,
  input  logic [7:0] rx_data,
  input  logic       rx_brk,
  input  logic       rx_fe,
  input  logic       rx_pe,
  input  logic       tx_take,
  input  logic       tx_idle,
  output logic [7:0] status,
  output logic [7:0] rhr,
  output logic [7:0] thr,
  output logic       tx_load
);
  logic rxrdy, txrdy, f_brk, f_fe, f_pe, f_ovr;
  logic push_ok;
  logic overrun_ev;

  assign push_ok    = rx_push && rx_en;
  assign overrun_ev = push_ok && rxrdy && !rhr_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxrdy <= 1'b0; f_brk <= 1'b0; f_fe <= 1'b0; f_pe <= 1'b0; f_ovr <= 1'b0;
      rhr   <= 8'h00;
    end else if (rx_rst_ev) begin
      rxrdy <= 1'b0; f_brk <= 1'b0; f_fe <= 1'b0; f_pe <= 1'b0; f_ovr <= 1'b0;
    end else if (push_ok) begin
      rhr   <= rx_data;
      rxrdy <= 1'b1;
      f_brk <= rx_brk;
      f_fe  <= rx_fe;
      f_pe  <= rx_pe;
      if (overrun_ev) f_ovr <= 1'b1;
    end else if (rhr_rd) begin
      rxrdy <= 1'b0;
      f_brk <= 1'b0;
      f_fe  <= 1'b0;
      f_pe  <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txrdy   <= 1'b1;
      thr     <= 8'h00;
      tx_load <= 1'b0;
    end else begin
      tx_load <= thr_wr;
      if (thr_wr) begin
        thr   <= wdata;
        txrdy <= 1'b0;
      end else if (tx_take || tx_rst_ev) begin
        txrdy <= 1'b1;
      end
    end
  end

  assign status = pack_status(f_brk, f_fe, f_pe, f_ovr, txrdy && tx_idle, txrdy, rxrdy);

  AST_RXRDY_SET: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push && rx_en && !rx_rst_ev |=> rxrdy); // R9
  AST_PUSH_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push && !rx_en && !rxrdy |=> !rxrdy); // R9
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    f_ovr && !rx_rst_ev |=> f_ovr); // R10
  AST_TXRDY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    thr_wr |=> !txrdy && tx_load); // R11
  AST_TXRST_READY: assert property (@(posedge clk) disable iff (!rst_n)
    tx_rst_ev && !thr_wr |=> txrdy); // R12
  AST_RXRST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    rx_rst_ev |=> !rxrdy && !f_ovr && !f_brk && !f_fe && !f_pe); // R12
endmodule

// File: rtl/uart_chan_regs.sv
module uart_chan_regs
  import uchr_pkg::*;
#(
  parameter int ADDR_W     = 6,
  parameter int STRIDE_LG2 = 5,
  parameter int CHAN_IDX   = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              core_rx_en,
  output logic              core_tx_en,
  output logic              core_rx_rst,
  output logic              core_tx_rst,
  output logic              core_brk,
  output logic [1:0]        core_len_code,
  output logic              core_par_on,
  output logic              core_par_odd,
  output logic              core_stop2,
  output logic [3:0]        core_frame_bits,
  output logic [3:0]        core_rx_baud,
  output logic [3:0]        core_tx_baud,
  output logic [7:0]        core_tx_data,
  output logic              core_tx_load,
  input  logic              core_tx_take,
  input  logic              core_tx_idle,
  input  logic              core_rx_push,
  input  logic [7:0]        core_rx_data,
  input  logic              core_rx_brk,
  input  logic              core_rx_fe,
  input  logic              core_rx_pe
);
  logic chan_hit, mode_wr, csr_wr, cmd_wr, thr_wr, mode_rd, sr_rd, rhr_rd;
  logic ptr_rst_ev, rx_rst_ev, tx_rst_ev, ptr_at_mr2;
  logic [7:0] mr1, mr2, csr, status, rhr;
  frame_cfg_t cfg;

  uchr_addr_dec #(.ADDR_W(ADDR_W), .STRIDE_LG2(STRIDE_LG2), .CHAN_IDX(CHAN_IDX)) i_dec (
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr), .chan_hit(chan_hit),
    .mode_wr(mode_wr), .csr_wr(csr_wr), .cmd_wr(cmd_wr), .thr_wr(thr_wr),
    .mode_rd(mode_rd), .sr_rd(sr_rd), .rhr_rd(rhr_rd)
  );

  uchr_cmd i_cmd (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .wdata(bus_wdata),
    .ptr_rst_ev(ptr_rst_ev), .rx_rst_ev(rx_rst_ev), .tx_rst_ev(tx_rst_ev),
    .rx_en(core_rx_en), .tx_en(core_tx_en), .brk_on(core_brk),
    .rx_rst_pulse(core_rx_rst), .tx_rst_pulse(core_tx_rst)
  );

  uchr_mode_regs i_mode (
    .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .csr_wr(csr_wr),
    .ptr_rst(ptr_rst_ev), .wdata(bus_wdata), .mr1(mr1), .mr2(mr2), .csr(csr),
    .ptr_at_mr2(ptr_at_mr2), .cfg(cfg)
  );

  uchr_status i_stat (
    .clk(clk), .rst_n(rst_n), .rx_en(core_rx_en), .rx_rst_ev(rx_rst_ev),
    .tx_rst_ev(tx_rst_ev), .rhr_rd(rhr_rd), .thr_wr(thr_wr), .wdata(bus_wdata),
    .rx_push(core_rx_push), .rx_data(core_rx_data), .rx_brk(core_rx_brk),
    .rx_fe(core_rx_fe), .rx_pe(core_rx_pe), .tx_take(core_tx_take),
    .tx_idle(core_tx_idle), .status(status), .rhr(rhr), .thr(core_tx_data),
    .tx_load(core_tx_load)
  );

  assign core_len_code   = cfg.len_code;
  assign core_par_on     = cfg.par_on;
  assign core_par_odd    = cfg.par_odd;
  assign core_stop2      = cfg.stop2;
  assign core_frame_bits = frame_bits(cfg);
  assign core_rx_baud    = csr[7:4];
  assign core_tx_baud    = csr[3:0];

  always_comb begin
    bus_rdata = 8'h00;
    if (mode_rd)     bus_rdata = ptr_at_mr2 ? mr2 : mr1;
    else if (sr_rd)  bus_rdata = status;
    else if (rhr_rd) bus_rdata = rhr;
  end

  AST_FOREIGN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && !chan_hit |=> $stable(mr1) && $stable(mr2) && $stable(csr)
                            && $stable(core_rx_en) && $stable(core_tx_en)); // R1
  AST_FOREIGN_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd && !chan_hit |-> bus_rdata == 8'h00); // R1
endmodule

// File: tb/test_uart_chan_regs.sv
module test_uart_chan_regs;
  localparam int AW = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 0, bus_rd = 0;
  logic [AW-1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic rx_en, tx_en, rx_rst, tx_rst, brk, par_on, par_odd, stop2, tx_load;
  logic [1:0] len_code;
  logic [3:0] fbits, rxb, txb;
  logic [7:0] tx_data;
  logic tx_take = 0, tx_idle = 1, rx_push = 0, rx_brk = 0, rx_fe = 0, rx_pe = 0;
  logic [7:0] rx_data = '0;

  always #5 clk = ~clk;

  uart_chan_regs #(.ADDR_W(AW), .STRIDE_LG2(5), .CHAN_IDX(1)) i_uart_chan_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .core_rx_en(rx_en), .core_tx_en(tx_en),
    .core_rx_rst(rx_rst), .core_tx_rst(tx_rst), .core_brk(brk), .core_len_code(len_code),
    .core_par_on(par_on), .core_par_odd(par_odd), .core_stop2(stop2),
    .core_frame_bits(fbits), .core_rx_baud(rxb), .core_tx_baud(txb),
    .core_tx_data(tx_data), .core_tx_load(tx_load), .core_tx_take(tx_take),
    .core_tx_idle(tx_idle), .core_rx_push(rx_push), .core_rx_data(rx_data),
    .core_rx_brk(rx_brk), .core_rx_fe(rx_fe), .core_rx_pe(rx_pe)
  );

  typedef struct { int sel; logic [15:0] exp; string req; } item_t;
  item_t sb[$];
  int checks = 0, errors = 0;
  logic [7:0] rd_cap = '0;
  bit done = 0;

  localparam int S_RD = 0, S_CTL = 1, S_CFG = 2, S_BAUD = 3, S_TXD = 4, S_BITS = 5, S_PUL = 6;

  function automatic logic [15:0] observe(int sel);
    case (sel)
      S_RD:   return {8'h0, rd_cap};
      S_CTL:  return {13'h0, rx_en, tx_en, brk};
      S_CFG:  return {11'h0, len_code, par_on, par_odd, stop2};
      S_BAUD: return {8'h0, rxb, txb};
      S_TXD:  return {8'h0, tx_data};
      S_BITS: return {12'h0, fbits};
      default: return {13'h0, rx_rst, tx_rst, tx_load};
    endcase
  endfunction

  // expected frame length restated from R3: start + (5+code) + parity + stop(s)
  function automatic logic [15:0] exp_bits(int code, int par, int two);
    return 16'(1 + 5 + code + par + (two ? 2 : 1));
  endfunction

  always @(negedge clk) begin
    while (sb.size() > 0) begin
      item_t it;
      logic [15:0] act;
      it = sb.pop_front();
      act = observe(it.sel);
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s sel=%0d actual=%h expected=%h", it.req, it.sel, act, it.exp);
      end
    end
  end

  task automatic expect_item(int sel, logic [15:0] exp, string req);
    item_t it;
    it.sel = sel; it.exp = exp; it.req = req;
    sb.push_back(it);
  endtask

  task automatic wr(logic [AW-1:0] a, logic [7:0] d);
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 0;
  endtask

  task automatic rd(logic [AW-1:0] a, logic [7:0] exp, string req);
    @(negedge clk);
    bus_rd = 1; bus_addr = a;
    #1 rd_cap = bus_rdata;
    @(posedge clk); #1;
    bus_rd = 0;
    expect_item(S_RD, {8'h0, exp}, req);
  endtask

  task automatic push(logic [7:0] d, logic b, logic f, logic p);
    @(negedge clk);
    rx_push = 1; rx_data = d; rx_brk = b; rx_fe = f; rx_pe = p;
    @(posedge clk); #1;
    rx_push = 0; rx_brk = 0; rx_fe = 0; rx_pe = 0;
  endtask

  task automatic idle();
    @(posedge clk); #1;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R13 reset state
    rd(6'h24, 8'h0C, "R13 status after reset");
    expect_item(S_CTL, 16'h0, "R13 enables and break off");
    expect_item(S_BAUD, 16'h00BB, "R13 rate select");
    expect_item(S_CFG, 16'b11000, "R13 frame config");
    expect_item(S_BITS, exp_bits(3, 0, 0), "R3 reset frame length");
    rd(6'h20, 8'h13, "R13 MR1 value");
    rd(6'h20, 8'h13, "R2 read does not advance");
    // R2 / R3 / R4 mode pointer
    wr(6'h20, 8'h02);
    expect_item(S_CFG, 16'b10100, "R3 7 bits parity even");
    expect_item(S_BITS, exp_bits(2, 1, 0), "R3 frame length with parity");
    rd(6'h20, 8'h07, "R2 pointer moved to MR2");
    wr(6'h20, 8'h0F);
    expect_item(S_CFG, 16'b10101, "R4 two stop bits");
    expect_item(S_BITS, exp_bits(2, 1, 1), "R4 frame length");
    wr(6'h20, 8'h07);
    expect_item(S_CFG, 16'b10100, "R2 stays on MR2, R4 one stop");
    wr(6'h28, 8'h10);
    wr(6'h20, 8'h14);
    expect_item(S_CFG, 16'b00010, "R3 odd flag, no parity, 5 bits");
    expect_item(S_BITS, exp_bits(0, 0, 0), "R3 shortest frame");
    rd(6'h20, 8'h07, "R2 pointer after reset cmd");
    // R1 foreign window
    wr(6'h00, 8'hFF);
    wr(6'h08, 8'h05);
    wr(6'h04, 8'h12);
    expect_item(S_CFG, 16'b00010, "R1 foreign write ignored");
    expect_item(S_CTL, 16'h0, "R1 foreign command ignored");
    expect_item(S_BAUD, 16'h00BB, "R1 foreign rate ignored");
    rd(6'h04, 8'h00, "R1 foreign read zero");
    // R5
    wr(6'h24, 8'hC6);
    expect_item(S_BAUD, 16'h00C6, "R5 rate nibbles");
    // R6
    wr(6'h28, 8'h05);
    expect_item(S_CTL, 16'b110, "R6 both enabled");
    wr(6'h28, 8'h03);
    expect_item(S_CTL, 16'b010, "R6 off wins");
    wr(6'h28, 8'h01);
    // R7
    wr(6'h28, 8'h60);
    expect_item(S_CTL, 16'b111, "R7 break on");
    wr(6'h28, 8'h70);
    expect_item(S_CTL, 16'b110, "R7 break off");
    wr(6'h28, 8'h60);
    wr(6'h28, 8'h30);
    expect_item(S_PUL, 16'b010, "R7 tx reset pulse");
    expect_item(S_CTL, 16'b100, "R7 tx reset clears tx and break");
    idle();
    expect_item(S_PUL, 16'b000, "R7 pulse one cycle");
    wr(6'h28, 8'h34);
    expect_item(S_CTL, 16'b110, "R7 reset with re-enable");
    wr(6'h28, 8'h20);
    expect_item(S_PUL, 16'b100, "R7 rx reset pulse");
    expect_item(S_CTL, 16'b010, "R7 rx reset clears rx");
    wr(6'h28, 8'h40);
    expect_item(S_CTL, 16'b010, "R7 unused code no effect");
    wr(6'h28, 8'h01);
    // R9 receive
    push(8'h41, 0, 0, 0);
    rd(6'h24, 8'h0D, "R9 receiver ready");
    rd(6'h2C, 8'h41, "R9 holding data");
    rd(6'h24, 8'h0C, "R9 ready cleared by read");
    wr(6'h28, 8'h02);
    push(8'h55, 0, 0, 0);
    rd(6'h24, 8'h0C, "R9 push ignored while disabled");
    wr(6'h28, 8'h01);
    // R10 overrun, R8 flag layout
    push(8'h11, 0, 1, 0);
    rd(6'h24, 8'h4D, "R8 framing flag bit 6");
    push(8'h22, 0, 0, 0);
    rd(6'h24, 8'h1D, "R10 overrun set");
    rd(6'h2C, 8'h22, "R10 newest char held");
    rd(6'h24, 8'h1C, "R10 overrun sticky");
    push(8'h33, 1, 0, 1);
    rd(6'h24, 8'hBD, "R8 break and parity flags");
    // R9 collision: read and push together
    @(negedge clk);
    bus_rd = 1; bus_addr = 6'h2C; rx_push = 1; rx_data = 8'h44;
    #1 rd_cap = bus_rdata;
    @(posedge clk); #1;
    bus_rd = 0; rx_push = 0;
    expect_item(S_RD, 16'h0033, "R9 collision returns old char");
    rd(6'h24, 8'h1D, "R9 collision keeps ready, no new overrun");
    rd(6'h2C, 8'h44, "R9 collision new char");
    wr(6'h28, 8'h20);
    rd(6'h24, 8'h0C, "R12 rx reset clears flags");
    // R11 transmit
    wr(6'h2C, 8'hA5);
    expect_item(S_PUL, 16'b001, "R11 load pulse");
    expect_item(S_TXD, 16'h00A5, "R11 transmit byte");
    rd(6'h24, 8'h00, "R11 ready cleared");
    @(negedge clk); tx_idle = 0; tx_take = 1;
    @(posedge clk); #1 tx_take = 0;
    rd(6'h24, 8'h04, "R11 ready, not empty");
    @(negedge clk); tx_idle = 1;
    rd(6'h24, 8'h0C, "R11 empty when idle");
    @(negedge clk);
    bus_wr = 1; bus_addr = 6'h2C; bus_wdata = 8'h5A; tx_take = 1;
    @(posedge clk); #1;
    bus_wr = 0; tx_take = 0;
    rd(6'h24, 8'h00, "R11 write wins over take");
    wr(6'h28, 8'h30);
    rd(6'h24, 8'h0C, "R12 tx reset sets ready");
    repeat (3) @(posedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule